// File: doc/BRIEF.md
# Block-Erase Sequencer

This controller-side engine erases a run of consecutive flash blocks without any help from software. A single request names the first block and how many blocks to erase. For each block, the engine drives the two-step erase command (20h, then D0h) to an address inside that block. It then waits for the device to report that it is no longer busy, and moves on to the next block. Readiness comes from either of two sources: the device's ready pin, or bit 7 of the status byte. The engine fetches a fresh status byte with a new output-enable pulse on every poll.

The engine reads the full status only once, after the last block. It turns that status into a result code. It then always clears the status register (50h) and returns the device to read-array mode (FFh). Finally it pulses `done` with the result.

The request side is a valid/ready port. `req_ready` is high only while the engine is idle. A request is taken on the cycle where `req_valid` and `req_ready` are both high. The requester holds its fields stable until then. The result side has no back-pressure: `done` is a one-cycle pulse, and `result` is valid in that cycle.

Top module: `blk_erase_seq`

## Requirements
- R1: `req_ready` is high exactly when the engine is idle, and the flash strobes are inactive whenever it is high. A request arriving while a run is active is ignored, and it leaves no trace in the bus traffic of that run.
- R2: For blocks `first`, `first+1`, …, `first+count-1`, in ascending order, the engine writes 20h and then D0h. The address of each write is the block number in the top `BLK_W` address bits, with all lower bits zero.
- R3: Every bus cycle drives the address (and the data, on a write) one cycle before the strobe falls, and holds it until one cycle after the strobe rises. `fl_we_n` or `fl_oe_n` stays low for exactly `STRB_CYC` cycles. The two strobes are never low together.
- R4: After each confirm write, the engine repeats read cycles, each with a new `fl_oe_n` pulse. It continues once `fl_ready` is high at the end of a read, or the byte read has bit 7 set.
- R5: The full status read happens once, after the last block has gone ready, and never between blocks.
- R6: The result codes are 0 success, 1 supply low, 2 command-sequence error, 3 erase error and 4 timeout. They are decoded from the final status in this order: bit 3 set gives 1; otherwise bits 4 and 5 both set give 2; otherwise bit 5 set gives 3; otherwise the code is 0.
- R7: Every run with a non-zero count ends with a 50h write, then an FFh write, both to the address of the last block written. This is followed by a `done` pulse lasting exactly one cycle.
- R8: If one block stays busy for more than `TMO_CYC` cycles of polling, the remaining blocks are skipped and no status read is made. The run ends with the 50h/FFh tail and result code 4.
- R9: A request with a count of zero produces no bus cycle and reports code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_first_blk | input | BLK_W | First block to erase |
| req_blk_cnt | input | CNT_W | Number of blocks to erase |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 3 | Result code, valid while `done` is high |
| fl_addr | output | ADDR_W | Flash address |
| fl_dout | output | 8 | Flash write data |
| fl_din | input | 8 | Flash read data |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash read strobe, active low |
| fl_ready | input | 1 | Device ready pin, high when not busy |

## Verification
The assertions check on every cycle the bus rules that hold at all times. The two strobes never overlap, the address and data do not move while a strobe is low, `done` never lasts longer than one cycle, and the strobes are idle whenever a request can be accepted. They also tie the status byte seen at the final read, and a poll that times out, to the code that is then latched. Only the bench scenarios, run against a behavioural flash model, can show the remaining behaviour: the exact order and addresses of the commands across several blocks, that readiness is still detected by the status bit when the ready pin never rises, the priority between an injected low supply and a bad confirm byte, and that a request made mid-run is dropped.

// File: rtl/blk_erase_pkg.sv
package blk_erase_pkg;

  typedef enum logic [2:0] {
    RES_OK    = 3'd0,
    RES_VPP   = 3'd1,
    RES_SEQ   = 3'd2,
    RES_ERASE = 3'd3,
    RES_TMO   = 3'd4
  } efs_res_e;

  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLRSR   = 8'h50;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;

  localparam int SR_RDY = 7;
  localparam int SR_ERS = 5;
  localparam int SR_SEQ = 4;
  localparam int SR_VPP = 3;

endpackage

// File: rtl/bes_bus_cycle.sv
module bes_bus_cycle #(
  parameter int ADDR_W   = 20,
  parameter int STRB_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              busy,
  output logic              fin,
  output logic [7:0]        rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dout,
  input  logic [7:0]        fl_din,
  output logic              fl_we_n,
  output logic              fl_oe_n
);
  localparam int CW = $clog2(STRB_CYC + 1);

  typedef enum logic [1:0] {P_IDLE, P_SET, P_STRB, P_HOLD} phase_e;
  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          rd_q;

  assign busy = (ph != P_IDLE);
  assign fin  = (ph == P_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= P_IDLE;
      cnt     <= '0;
      rd_q    <= 1'b0;
      fl_addr <= '0;
      fl_dout <= '0;
      rdata   <= '0;
      fl_we_n <= 1'b1;
      fl_oe_n <= 1'b1;
    end else begin
      case (ph)
        P_IDLE: if (go) begin
          fl_addr <= addr;
          fl_dout <= wdata;
          rd_q    <= rd;
          ph      <= P_SET;
        end
        P_SET: begin
          cnt     <= '0;
          fl_we_n <= rd_q;
          fl_oe_n <= !rd_q;
          ph      <= P_STRB;
        end
        P_STRB: begin
          if (cnt == CW'(STRB_CYC - 1)) begin
            fl_we_n <= 1'b1;
            fl_oe_n <= 1'b1;
            if (rd_q) rdata <= fl_din;
            ph <= P_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= P_IDLE;
      endcase
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  // R3
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || !fl_oe_n) |-> ($stable(fl_addr) && $stable(fl_dout)));

endmodule

// File: rtl/bes_poll_timer.sv
module bes_poll_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);
  logic [TW-1:0] cnt;

  assign expired = (cnt == TW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  // R8
  tmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !expired);

endmodule

// File: rtl/bes_status_decode.sv
module bes_status_decode
  import blk_erase_pkg::*;
(
  input  logic [7:0] sr,
  output efs_res_e   code
);
  always_comb begin
    if (sr[SR_VPP])                    code = RES_VPP;
    else if (sr[SR_SEQ] && sr[SR_ERS]) code = RES_SEQ;
    else if (sr[SR_ERS])               code = RES_ERASE;
    else                               code = RES_OK;
  end
endmodule

// File: rtl/blk_erase_seq.sv
module blk_erase_seq
  import blk_erase_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int BLK_W    = 4,
  parameter int CNT_W    = BLK_W + 1,
  parameter int STRB_CYC = 3,
  parameter int TMO_CYC  = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BLK_W-1:0]  req_first_blk,
  input  logic [CNT_W-1:0]  req_blk_cnt,
  output logic              done,
  output logic [2:0]        result,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dout,
  input  logic [7:0]        fl_din,
  output logic              fl_we_n,
  output logic              fl_oe_n,
  input  logic              fl_ready
);
  localparam int OFS_W = ADDR_W - BLK_W;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_CONF, S_POLL, S_STAT, S_CLR, S_ARR, S_FIN
  } seq_e;

  seq_e             state;
  logic [BLK_W-1:0] blk_q;
  logic [CNT_W-1:0] left_q;
  efs_res_e         code_q;
  efs_res_e         dec_code;
  logic             issued;
  logic             bus_go, bus_rd, cyc_busy, cyc_fin, tmo_exp;
  logic [7:0]       bus_data, rdata;

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_FIN);
  assign result    = code_q;

  always_comb begin
    bus_rd   = 1'b0;
    bus_data = CMD_ARRAY;
    case (state)
      S_SETUP: bus_data = CMD_ERASE;
      S_CONF:  bus_data = CMD_CONFIRM;
      S_POLL:  bus_rd   = 1'b1;
      S_STAT:  bus_rd   = 1'b1;
      S_CLR:   bus_data = CMD_CLRSR;
      default: bus_data = CMD_ARRAY;
    endcase
    bus_go = !issued && !cyc_busy &&
             (state != S_IDLE) && (state != S_FIN);
  end

  bes_bus_cycle #(.ADDR_W(ADDR_W), .STRB_CYC(STRB_CYC)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(bus_go), .rd(bus_rd),
    .addr({blk_q, {OFS_W{1'b0}}}), .wdata(bus_data),
    .busy(cyc_busy), .fin(cyc_fin), .rdata(rdata),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  bes_poll_timer #(.LIMIT(TMO_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(state != S_POLL), .expired(tmo_exp)
  );

  bes_status_decode u_dec (.sr(rdata), .code(dec_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      blk_q  <= '0;
      left_q <= '0;
      code_q <= RES_OK;
      issued <= 1'b0;
    end else begin
      if (bus_go)       issued <= 1'b1;
      else if (cyc_fin) issued <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          blk_q  <= req_first_blk;
          left_q <= req_blk_cnt;
          code_q <= RES_OK;
          state  <= (req_blk_cnt == '0) ? S_FIN : S_SETUP;
        end
        S_SETUP: if (cyc_fin) state <= S_CONF;
        S_CONF:  if (cyc_fin) state <= S_POLL;
        S_POLL: if (cyc_fin) begin
          if (fl_ready || rdata[SR_RDY]) begin
            if (left_q == CNT_W'(1)) state <= S_STAT;
            else begin
              blk_q  <= blk_q + 1'b1;
              left_q <= left_q - 1'b1;
              state  <= S_SETUP;
            end
          end else if (tmo_exp) begin
            code_q <= RES_TMO;
            state  <= S_CLR;
          end
        end
        S_STAT: if (cyc_fin) begin
          code_q <= dec_code;
          state  <= S_CLR;
        end
        S_CLR: if (cyc_fin) state <= S_ARR;
        S_ARR: if (cyc_fin) state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_we_n && fl_oe_n));

  // R6
  vpp_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STAT && cyc_fin && rdata[SR_VPP]) |=> (result == 3'd1));

  // R8
  tmo_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL && cyc_fin && !fl_ready && !rdata[SR_RDY] && tmo_exp)
      |=> (result == 3'd4));

endmodule

// File: tb/blk_erase_seq_tb.sv
module blk_erase_seq_tb;
  localparam int ADDR_W = 20;
  localparam int BLK_W  = 4;
  localparam int CNT_W  = 5;
  localparam int STRB   = 3;
  localparam int TMO    = 300;
  localparam int ERASE_T = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [BLK_W-1:0] req_first_blk = '0;
  logic [CNT_W-1:0] req_blk_cnt = '0;
  logic done;
  logic [2:0] result;
  logic [ADDR_W-1:0] fl_addr;
  logic [7:0] fl_dout, fl_din;
  logic fl_we_n, fl_oe_n, fl_ready;

  always #2.5 clk = ~clk;

  blk_erase_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .CNT_W(CNT_W),
                  .STRB_CYC(STRB), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_first_blk(req_first_blk), .req_blk_cnt(req_blk_cnt),
    .done(done), .result(result), .fl_addr(fl_addr), .fl_dout(fl_dout),
    .fl_din(fl_din), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_ready(fl_ready)
  );

  // flash command/status model
  bit inj_vpp = 0, inj_bad = 0, inj_ers = 0, inj_stuck = 0, pin_dead = 0;
  int busy_cnt = 0;
  bit setup_pend = 0, sr3 = 0, sr4 = 0, sr5 = 0;
  logic [7:0] snap = 8'h80;
  logic [7:0] cmd;

  assign fl_din   = snap;
  assign fl_ready = pin_dead ? 1'b0 : (busy_cnt == 0);

  always @(negedge fl_oe_n)
    snap = {(busy_cnt == 0), 1'b0, sr5, sr4, sr3, 3'b000};

  always @(posedge fl_we_n) begin
    cmd = fl_dout;
    if (setup_pend) begin
      setup_pend = 0;
      if (inj_vpp) begin sr3 = 1; sr5 = 1; end
      if (cmd != 8'hD0 || inj_bad) begin sr4 = 1; sr5 = 1; end
      else if (!inj_vpp) busy_cnt = ERASE_T;
    end else if (cmd == 8'h20) setup_pend = 1;
    else if (cmd == 8'h50) begin sr3 = 0; sr4 = 0; sr5 = 0; end
  end

  always @(posedge clk)
    if (busy_cnt > 0 && !inj_stuck) begin
      busy_cnt = busy_cnt - 1;
      if (busy_cnt == 0 && inj_ers) sr5 = 1;
    end

  // scoreboard
  logic [ADDR_W+7:0] exp_wr[$];
  logic [2:0]        exp_res[$];
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] blk_addr(input int b);
    return {b[BLK_W-1:0], {(ADDR_W-BLK_W){1'b0}}};
  endfunction

  // monitor
  bit prev_we = 1;
  int we_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_we_n) we_len++;
      if (!prev_we && fl_we_n) begin
        chk(we_len == STRB, "R3 write strobe width", we_len, STRB);
        if (exp_wr.size() == 0)
          chk(0, "R2 unexpected write", {fl_addr, fl_dout}, 0);
        else begin
          logic [ADDR_W+7:0] e;
          e = exp_wr.pop_front();
          chk({fl_addr, fl_dout} == e, "R2/R7 write address+data",
              {fl_addr, fl_dout}, e);
        end
        we_len = 0;
      end
      if (done) begin
        chk(exp_wr.size() == 0, "R7 writes complete before done", exp_wr.size(), 0);
        if (exp_res.size() == 0) chk(0, "R6 unexpected done", result, 0);
        else begin
          logic [2:0] r;
          r = exp_res.pop_front();
          chk(result == r, "R6/R8/R9 result code", result, r);
        end
      end
    end
    prev_we = fl_we_n;
  end

  task automatic run(input int first, input int cnt, input int nblk,
                     input logic [2:0] code, input bit poke_busy);
    busy_cnt = 0; setup_pend = 0; sr3 = 0; sr4 = 0; sr5 = 0;
    for (int i = 0; i < nblk; i++) begin
      exp_wr.push_back({blk_addr(first + i), 8'h20});
      exp_wr.push_back({blk_addr(first + i), 8'hD0});
    end
    if (cnt != 0) begin
      exp_wr.push_back({blk_addr(first + nblk - 1), 8'h50});
      exp_wr.push_back({blk_addr(first + nblk - 1), 8'hFF});
    end
    exp_res.push_back(code);
    @(negedge clk);
    req_first_blk = first[BLK_W-1:0];
    req_blk_cnt   = cnt[CNT_W-1:0];
    req_valid     = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      // R1: request during a run is ignored
      chk(req_ready == 1'b0, "R1 ready low while running", req_ready, 0);
      req_first_blk = 4'd9; req_blk_cnt = 5'd1; req_valid = 1'b1;
      repeat (30) @(negedge clk);
      req_valid = 1'b0;
    end
    wait (exp_res.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(done == 1'b0, "R7 reset done", done, 0);
    chk(fl_we_n && fl_oe_n, "R3 reset strobes idle", {fl_we_n, fl_oe_n}, 3);

    run(3, 1, 1, 3'd0, 0);                       // R2 single block
    pin_dead = 1;                                 // R4 status-bit polling only
    run(5, 3, 3, 3'd0, 1);                        // R2 R5 R1 multi-block
    pin_dead = 0;
    inj_vpp = 1; run(1, 2, 2, 3'd1, 0); inj_vpp = 0;          // R6 supply low
    inj_bad = 1; run(7, 1, 1, 3'd2, 0); inj_bad = 0;          // R6 bad confirm
    inj_vpp = 1; inj_bad = 1; run(0, 2, 2, 3'd1, 0);          // R6 priority
    inj_vpp = 0; inj_bad = 0;
    inj_ers = 1; run(12, 2, 2, 3'd3, 0); inj_ers = 0;         // R6 erase error
    inj_stuck = 1; run(2, 3, 1, 3'd4, 0); inj_stuck = 0;      // R8 timeout
    run(6, 0, 0, 3'd0, 0);                                    // R9 zero count
    run(15, 1, 1, 3'd0, 0);                                   // R2 top block
    summary();
  end
endmodule